// File: doc/BRIEF.md
# Register Rename Map with Free Pool

This block is the renaming stage of an out-of-order core. It translates architectural register numbers into physical register tags. There are 32 logical registers and 64 physical registers, and the values themselves live in a shared physical file outside the block. Each cycle one instruction may be presented for rename. The block returns the physical tags of its two sources. If the instruction writes a register, the block also returns a freshly allocated destination tag and the tag that the destination previously mapped to.

Two maps are held. The speculative map is updated at rename and feeds later readers. The committed map is updated when an instruction retires. A retire moves no data: the committed entry is pointed at the new tag, and the tag that held the older committed value goes back to the free pool. A flush discards all speculative state. It restores the speculative map from the committed map and rebuilds the free pool from every tag the committed map does not use.

Top module: `rnm_rename`

## Requirements
- R1: After reset, logical register i maps to physical tag i (i = 0..31). The free pool holds tags 32..63 and hands them out in ascending order, so the first allocation yields 32.
- R2: For a rename request, `ren_tag_a` and `ren_tag_b` show in the same cycle the speculative mapping of `ren_src_a` and `ren_src_b`. Those mappings include every allocation accepted in earlier cycles.
- R3: An accepted rename with a destination receives the tag at the head of the free pool on `ren_tag_new`. `ren_tag_old` shows the destination's prior speculative mapping. From the next cycle on, readers of that logical register get the new tag.
- R4: When the free pool is empty, a rename with a destination sees `ren_ready` low. It allocates nothing and leaves the speculative map unchanged.
- R5: A rename without a destination is accepted (`ren_ready` high) even when the pool is empty, and it consumes no tag.
- R6: A commit with a destination sets the committed entry of `cmt_log` to `cmt_tag`. The tag that the committed map held for `cmt_log` before that commit is appended to the tail of the free pool.
- R7: An allocation and a release in the same cycle both take effect. The released tag is queued behind the tags already free.
- R8: A commit without a destination releases no tag and changes no map entry.
- R9: While `flush` is high, `ren_ready` is low and rename and commit requests are ignored. On the next cycle the speculative map equals the committed map. The free pool then holds the 32 tags that the committed map does not reference, in ascending order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ren_valid | input | 1 | Rename request present |
| ren_has_dst | input | 1 | Request writes a destination |
| ren_src_a | input | 5 | First source logical register |
| ren_src_b | input | 5 | Second source logical register |
| ren_dst | input | 5 | Destination logical register |
| ren_ready | output | 1 | Request accepted this cycle |
| ren_tag_a | output | 6 | Physical tag of first source |
| ren_tag_b | output | 6 | Physical tag of second source |
| ren_tag_new | output | 6 | Newly allocated destination tag |
| ren_tag_old | output | 6 | Previous speculative tag of destination |
| cmt_valid | input | 1 | Commit request present |
| cmt_has_dst | input | 1 | Committing instruction writes a destination |
| cmt_log | input | 5 | Logical register being committed |
| cmt_tag | input | 6 | Physical tag it was renamed to |
| flush | input | 1 | Restore speculative state from committed state |

## Verification
The bench drains the pool completely and then asks for more destinations. A design that pops an empty FIFO would hand out stale tags, and its later sources would disagree with the reference. Allocation and release are made to coincide, including in a cycle when the pool is empty, so that a counter which drops one of the two updates shows up as tags lost or duplicated later. Flushes are issued with rename and commit requests also asserted, and the pool is then emptied one tag at a time. This exposes a rebuild that keeps speculative tags, skips free ones or uses a different order, as well as any commit that slips through during the flush. Commits without a destination are mixed in, so that a stray release would appear as an extra tag in the allocation stream.

// File: rtl/rnm_pkg.sv
// Shared sizing defaults for the rename stage.
// Assumes: physical count exceeds logical count; both are powers of two.
package rnm_pkg;
    localparam int unsigned RNM_NUM_LOG  = 32;
    localparam int unsigned RNM_NUM_PHYS = 64;
endpackage

// File: rtl/rnm_map_table.sv
// Logical-to-physical map: RD_PORTS combinational lookups, one write port,
// and a whole-table load that takes priority over the write.
// Assumes: reset state is the identity mapping (entry i holds tag i).
module rnm_map_table #(
    parameter int unsigned NUM_LOG  = rnm_pkg::RNM_NUM_LOG,
    parameter int unsigned PHYS_W   = 6,
    parameter int unsigned RD_PORTS = 1,
    localparam int unsigned LOG_W   = $clog2(NUM_LOG)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [LOG_W-1:0]                 wr_idx,
    input  logic [PHYS_W-1:0]                wr_tag,
    input  logic                             load_en,
    input  logic [NUM_LOG-1:0][PHYS_W-1:0]   load_map,
    input  logic [RD_PORTS-1:0][LOG_W-1:0]   rd_idx,
    output logic [RD_PORTS-1:0][PHYS_W-1:0]  rd_tag,
    output logic [NUM_LOG-1:0][PHYS_W-1:0]   map_q
);

    // Table update: reset to identity, bulk load, or single-entry write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_LOG; i++) begin
                map_q[i] <= PHYS_W'(i);
            end
        end else if (load_en) begin
            map_q <= load_map;
        end else if (wr_en) begin
            map_q[wr_idx] <= wr_tag;
        end
    end

    // One asynchronous lookup per read port.
    for (genvar g = 0; g < RD_PORTS; g++) begin : g_rd
        assign rd_tag[g] = map_q[rd_idx[g]];
    end

endmodule

// File: rtl/rnm_free_fifo.sv
// Circular FIFO of free physical tags: one pop and one push per cycle, both
// honoured together. Rebuild refills it with every tag the given map leaves
// unreferenced, in ascending order.
// Assumes: caller never pops when empty or pushes when full; the map given
// for rebuild holds NUM_LOG distinct tags.
module rnm_free_fifo #(
    parameter int unsigned NUM_LOG  = rnm_pkg::RNM_NUM_LOG,
    parameter int unsigned NUM_PHYS = rnm_pkg::RNM_NUM_PHYS,
    localparam int unsigned PHYS_W  = $clog2(NUM_PHYS),
    localparam int unsigned DEPTH   = NUM_PHYS - NUM_LOG,
    localparam int unsigned PTR_W   = $clog2(DEPTH),
    localparam int unsigned CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            pop,
    input  logic                            push,
    input  logic [PHYS_W-1:0]               push_tag,
    input  logic                            rebuild,
    input  logic [NUM_LOG-1:0][PHYS_W-1:0]  ref_map,
    output logic [PHYS_W-1:0]               head_tag,
    output logic                            empty,
    output logic [CNT_W-1:0]                count
);

    logic [DEPTH-1:0][PHYS_W-1:0] mem_q;
    logic [DEPTH-1:0][PHYS_W-1:0] rb_mem;
    logic [NUM_PHYS-1:0]          used;
    logic [PTR_W-1:0]             head_q;
    logic [PTR_W-1:0]             tail_q;

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Mark tags referenced by the map, then pack the unreferenced ones in order.
    always_comb begin
        int slot;
        used   = '0;
        rb_mem = '0;
        slot   = 0;
        for (int l = 0; l < NUM_LOG; l++) begin
            used[ref_map[l]] = 1'b1;
        end
        for (int p = 0; p < NUM_PHYS; p++) begin
            if (!used[p]) begin
                if (slot < DEPTH) begin
                    rb_mem[slot[PTR_W-1:0]] = PHYS_W'(p);
                end
                slot = slot + 1;
            end
        end
    end

    // Storage, pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                mem_q[k] <= PHYS_W'(NUM_LOG + k);
            end
            head_q <= '0;
            tail_q <= '0;
            count  <= CNT_W'(DEPTH);
        end else if (rebuild) begin
            mem_q  <= rb_mem;
            head_q <= '0;
            tail_q <= '0;
            count  <= CNT_W'(DEPTH);
        end else begin
            if (pop) begin
                head_q <= bump(head_q);
            end
            if (push) begin
                mem_q[tail_q] <= push_tag;
                tail_q        <= bump(tail_q);
            end
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign head_tag = mem_q[head_q];
    assign empty    = (count == '0);

endmodule

// File: rtl/rnm_rename.sv
// Rename stage top: speculative map, committed map and free-tag FIFO.
// Rename answers combinationally in the request cycle; map and pool updates
// land at the next edge. Flush wins over rename and commit in its cycle.
// Assumes: commits arrive in program order and carry the tag from rename.
module rnm_rename #(
    parameter int unsigned NUM_LOG  = rnm_pkg::RNM_NUM_LOG,
    parameter int unsigned NUM_PHYS = rnm_pkg::RNM_NUM_PHYS,
    localparam int unsigned LOG_W   = $clog2(NUM_LOG),
    localparam int unsigned PHYS_W  = $clog2(NUM_PHYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ren_valid,
    input  logic              ren_has_dst,
    input  logic [LOG_W-1:0]  ren_src_a,
    input  logic [LOG_W-1:0]  ren_src_b,
    input  logic [LOG_W-1:0]  ren_dst,
    output logic              ren_ready,
    output logic [PHYS_W-1:0] ren_tag_a,
    output logic [PHYS_W-1:0] ren_tag_b,
    output logic [PHYS_W-1:0] ren_tag_new,
    output logic [PHYS_W-1:0] ren_tag_old,
    input  logic              cmt_valid,
    input  logic              cmt_has_dst,
    input  logic [LOG_W-1:0]  cmt_log,
    input  logic [PHYS_W-1:0] cmt_tag,
    input  logic              flush
);

    localparam int unsigned CNT_W = $clog2(NUM_PHYS - NUM_LOG + 1);

    logic [NUM_LOG-1:0][PHYS_W-1:0] spec_map_q;
    logic [NUM_LOG-1:0][PHYS_W-1:0] cmt_map_q;
    logic [2:0][LOG_W-1:0]          spec_rd_idx;
    logic [2:0][PHYS_W-1:0]         spec_rd_tag;
    logic [0:0][PHYS_W-1:0]         cmt_rd_tag;
    logic [PHYS_W-1:0]              pool_head;
    logic                           pool_empty;
    logic [CNT_W-1:0]               free_cnt;
    logic                           alloc;
    logic                           release_tag;

    // Accept/allocate/release decisions for this cycle.
    always_comb begin
        ren_ready   = !flush && (!ren_has_dst || !pool_empty);
        alloc       = ren_valid && ren_ready && ren_has_dst;
        release_tag = cmt_valid && cmt_has_dst && !flush;
    end

    assign spec_rd_idx = {ren_dst, ren_src_b, ren_src_a};

    rnm_map_table #(
        .NUM_LOG (NUM_LOG),
        .PHYS_W  (PHYS_W),
        .RD_PORTS(3)
    ) u_spec_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (alloc),
        .wr_idx  (ren_dst),
        .wr_tag  (pool_head),
        .load_en (flush),
        .load_map(cmt_map_q),
        .rd_idx  (spec_rd_idx),
        .rd_tag  (spec_rd_tag),
        .map_q   (spec_map_q)
    );

    rnm_map_table #(
        .NUM_LOG (NUM_LOG),
        .PHYS_W  (PHYS_W),
        .RD_PORTS(1)
    ) u_cmt_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (release_tag),
        .wr_idx  (cmt_log),
        .wr_tag  (cmt_tag),
        .load_en (1'b0),
        .load_map('0),
        .rd_idx  (cmt_log),
        .rd_tag  (cmt_rd_tag),
        .map_q   (cmt_map_q)
    );

    rnm_free_fifo #(
        .NUM_LOG (NUM_LOG),
        .NUM_PHYS(NUM_PHYS)
    ) u_pool (
        .clk     (clk),
        .rst_n   (rst_n),
        .pop     (alloc),
        .push    (release_tag),
        .push_tag(cmt_rd_tag[0]),
        .rebuild (flush),
        .ref_map (cmt_map_q),
        .head_tag(pool_head),
        .empty   (pool_empty),
        .count   (free_cnt)
    );

    assign ren_tag_a   = spec_rd_tag[0];
    assign ren_tag_b   = spec_rd_tag[1];
    assign ren_tag_old = spec_rd_tag[2];
    assign ren_tag_new = pool_head;

endmodule

// File: rtl/rnm_rename_chk.sv
// Property checker for the rename stage, attached by bind below.
// Assumes: the map and count signals of the bound instance are connected.
module rnm_rename_chk #(
    parameter int unsigned NUM_LOG  = 32,
    parameter int unsigned NUM_PHYS = 64,
    localparam int unsigned LOG_W   = $clog2(NUM_LOG),
    localparam int unsigned PHYS_W  = $clog2(NUM_PHYS),
    localparam int unsigned DEPTH   = NUM_PHYS - NUM_LOG,
    localparam int unsigned CNT_W   = $clog2(DEPTH + 1)
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           ren_valid,
    input logic                           ren_has_dst,
    input logic                           ren_ready,
    input logic [LOG_W-1:0]               ren_dst,
    input logic [PHYS_W-1:0]              ren_tag_new,
    input logic                           cmt_valid,
    input logic                           cmt_has_dst,
    input logic [LOG_W-1:0]               cmt_log,
    input logic [PHYS_W-1:0]              cmt_tag,
    input logic                           flush,
    input logic [NUM_LOG-1:0][PHYS_W-1:0] spec_map,
    input logic [NUM_LOG-1:0][PHYS_W-1:0] cmt_map,
    input logic [CNT_W-1:0]               free_cnt
);

    // R3
    spec_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_ready && ren_has_dst) |=>
        (spec_map[$past(ren_dst)] == $past(ren_tag_new)));

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && ren_has_dst && free_cnt == '0) |-> !ren_ready);

    // R5
    nodst_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ren_has_dst && !flush) |-> ren_ready);

    // R6
    cmt_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && cmt_has_dst && !flush) |=>
        (cmt_map[$past(cmt_log)] == $past(cmt_tag)));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt <= CNT_W'(DEPTH));

    // R8
    nodst_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_valid && !cmt_has_dst && !flush && !(ren_valid && ren_ready && ren_has_dst))
        |=> (free_cnt == $past(free_cnt)));

    // R9
    flush_rebuild_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (free_cnt == CNT_W'(DEPTH) && spec_map == cmt_map));

endmodule

bind rnm_rename rnm_rename_chk #(
    .NUM_LOG (NUM_LOG),
    .NUM_PHYS(NUM_PHYS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ren_valid  (ren_valid),
    .ren_has_dst(ren_has_dst),
    .ren_ready  (ren_ready),
    .ren_dst    (ren_dst),
    .ren_tag_new(ren_tag_new),
    .cmt_valid  (cmt_valid),
    .cmt_has_dst(cmt_has_dst),
    .cmt_log    (cmt_log),
    .cmt_tag    (cmt_tag),
    .flush      (flush),
    .spec_map   (spec_map_q),
    .cmt_map    (cmt_map_q),
    .free_cnt   (free_cnt)
);

// File: tb/rnm_rename_test.sv
`timescale 1ns/1ps
module rnm_rename_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ren_valid, ren_has_dst;
    logic [4:0] ren_src_a, ren_src_b, ren_dst;
    logic       ren_ready;
    logic [5:0] ren_tag_a, ren_tag_b, ren_tag_new, ren_tag_old;
    logic       cmt_valid, cmt_has_dst;
    logic [4:0] cmt_log;
    logic [5:0] cmt_tag;
    logic       flush;

    always #4 clk = ~clk;

    rnm_rename uut (
        .clk(clk), .rst_n(rst_n),
        .ren_valid(ren_valid), .ren_has_dst(ren_has_dst),
        .ren_src_a(ren_src_a), .ren_src_b(ren_src_b), .ren_dst(ren_dst),
        .ren_ready(ren_ready), .ren_tag_a(ren_tag_a), .ren_tag_b(ren_tag_b),
        .ren_tag_new(ren_tag_new), .ren_tag_old(ren_tag_old),
        .cmt_valid(cmt_valid), .cmt_has_dst(cmt_has_dst),
        .cmt_log(cmt_log), .cmt_tag(cmt_tag), .flush(flush)
    );

    typedef struct { int lg; int tg; } inflight_t;

    int        spec_m[32];
    int        cmt_m[32];
    int        pool[$];
    inflight_t rob[$];
    int        n_cmp = 0;
    int        n_bad = 0;
    bit        done  = 0;

    task automatic chk(input int act, input int exp, input string req, input string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Reference rebuild: unreferenced tags in ascending order.
    task automatic model_flush();
        bit used[64];
        for (int p = 0; p < 64; p++) used[p] = 0;
        for (int l = 0; l < 32; l++) begin
            spec_m[l] = cmt_m[l];
            used[cmt_m[l]] = 1;
        end
        pool.delete();
        for (int p = 0; p < 64; p++) if (!used[p]) pool.push_back(p);
        rob.delete();
    endtask

    // One cycle: drive, compare combinational outputs, clock, update model.
    task automatic cyc(input bit rv, input bit rd, input int a, input int b, input int d,
                       input bit cv, input bit cd, input int cl, input int ct,
                       input bit fl, input string phase);
        bit exp_ready;
        @(negedge clk);
        ren_valid = rv; ren_has_dst = rd;
        ren_src_a = 5'(a); ren_src_b = 5'(b); ren_dst = 5'(d);
        cmt_valid = cv; cmt_has_dst = cd; cmt_log = 5'(cl); cmt_tag = 6'(ct);
        flush = fl;
        #2;
        exp_ready = !fl && (!rd || pool.size() != 0);
        chk(int'(ren_ready), int'(exp_ready), fl ? "R9" : (rd ? "R4" : "R5"), {phase, " ready"});
        if (rv) begin
            chk(int'(ren_tag_a), spec_m[a], "R2", {phase, " src_a"});
            chk(int'(ren_tag_b), spec_m[b], "R2", {phase, " src_b"});
            if (rd) chk(int'(ren_tag_old), spec_m[d], "R3", {phase, " old tag"});
            if (rd && exp_ready) chk(int'(ren_tag_new), pool[0], "R3", {phase, " new tag"});
        end
        @(posedge clk);
        if (fl) begin
            model_flush();
        end else begin
            if (rv && rd && exp_ready) begin
                int t;
                inflight_t e;
                t = pool.pop_front();
                spec_m[d] = t;
                e.lg = d; e.tg = t;
                rob.push_back(e);
            end
            if (cv && cd) begin
                pool.push_back(cmt_m[cl]);
                cmt_m[cl] = ct;
            end
        end
    endtask

    task automatic ren_only(input bit rd, input int d, input string phase);
        cyc(1, rd, int'($urandom % 32), int'($urandom % 32), d, 0, 0, 0, 0, 0, phase);
    endtask

    task automatic ren_and_commit(input bit rv, input bit rd, input int d, input string phase);
        inflight_t e;
        e = rob.pop_front();
        cyc(rv, rd, int'($urandom % 32), int'($urandom % 32), d, 1, 1, e.lg, e.tg, 0, phase);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        report();
    end

    initial begin
        rst_n = 0; ren_valid = 0; ren_has_dst = 0; ren_src_a = 0; ren_src_b = 0;
        ren_dst = 0; cmt_valid = 0; cmt_has_dst = 0; cmt_log = 0; cmt_tag = 0; flush = 0;
        for (int i = 0; i < 32; i++) begin
            spec_m[i] = i; cmt_m[i] = i; pool.push_back(32 + i);
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R1: identity map and first free tag after reset
        for (int i = 0; i < 32; i++) begin
            cyc(1, 0, i, 31 - i, 0, 0, 0, 0, 0, 0, "R1 reset map");
            chk(int'(ren_tag_a), i, "R1", "identity src_a");
            chk(int'(ren_tag_b), 31 - i, "R1", "identity src_b");
            #1 chk(int'(ren_tag_new), 32, "R1", "first free tag");
        end

        // R2/R3: repeated destinations chain old/new tags
        for (int k = 0; k < 10; k++) ren_only(1, k % 5, "R3 rename chain");

        // R4: drain the pool then stall; R5: no-destination still accepted
        while (pool.size() != 0) ren_only(1, int'($urandom % 32), "R4 drain");
        for (int k = 0; k < 3; k++) ren_only(1, k, "R4 empty stall");
        for (int k = 0; k < 2; k++) ren_only(0, k, "R5 empty no-dst");

        // R7: release while empty, rename stalled in the same cycle
        ren_and_commit(1, 1, 7, "R7 empty release");
        // R6: in-order commits release prior committed tags
        for (int k = 0; k < 5; k++) ren_and_commit(0, 0, 0, "R6 commit");
        // R7: simultaneous allocate and release
        for (int k = 0; k < 6; k++) ren_and_commit(1, 1, k + 3, "R7 alloc+release");
        // R8: commits without destination free nothing
        for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 0, 1, 0, k, 63, 0, "R8 no-dst commit");
        while (pool.size() != 0) ren_only(1, int'($urandom % 32), "R8 drain check");
        ren_only(1, 4, "R8 empty after drain");

        // R9: flush with rename and commit also requested
        cyc(1, 1, 1, 2, 3, 1, 1, 5, 40, 1, "R9 flush");
        for (int i = 0; i < 32; i++) cyc(1, 0, i, i, 0, 0, 0, 0, 0, 0, "R9 restored map");
        while (pool.size() != 0) ren_only(1, int'($urandom % 32), "R9 rebuilt order");

        // Mixed traffic
        for (int n = 0; n < 3000; n++) begin
            bit rv, rd, fl;
            rv = ($urandom % 4) != 0;
            rd = ($urandom % 3) != 0;
            fl = ($urandom % 200) == 0;
            if (!fl && rob.size() != 0 && ($urandom % 3) == 0)
                ren_and_commit(rv, rd, int'($urandom % 32), "R7 mixed");
            else
                cyc(rv, rd, int'($urandom % 32), int'($urandom % 32), int'($urandom % 32),
                    ($urandom % 5) == 0, 0, int'($urandom % 32), 0, fl, fl ? "R9 mixed" : "R2 mixed");
        end

        report();
    end

endmodule